// File: doc/BRIEF.md
# LIN Slave Frame Response Controller

This block is the frame-level engine of a LIN slave node. A byte receiver in front of it reports a break condition and hands over whole bytes. The engine checks the sync byte and the protected identifier. It then stalls the frame and raises a data request to the host. The host reads the identifier and picks the direction of the response and its length. For a published response it also fills the data buffer. It then either acknowledges the frame or stops the node until the next break.

Once acknowledged, the engine either collects the data bytes and checks the checksum, or feeds the buffer bytes and the checksum it computes to a byte transmitter through a valid/ready handshake. The checksum is the classic kind or the enhanced kind, which also covers the identifier. Each outcome is reported through a done flag or an error bit, and each raises a sticky interrupt.

The controller moves through nine states: `ST_IDLE`, `ST_SYNC`, `ST_PID`, `ST_WAIT_HOST`, `ST_RX_DATA`, `ST_RX_CKSUM`, `ST_TX_DATA`, `ST_TX_CKSUM` and `ST_HALT`. The transitions are:
- Break: from any state to `ST_SYNC`, unless the engine is held in master mode.
- Sync check in `ST_SYNC`: a good sync byte goes to `ST_PID`; a bad one goes to `ST_IDLE`.
- Parity check in `ST_PID`: good parity goes to `ST_WAIT_HOST`; bad parity goes to `ST_IDLE`.
- Host decision in `ST_WAIT_HOST`:
  - acknowledge goes to `ST_RX_DATA` or `ST_TX_DATA`, or straight to the matching checksum state when the length is zero;
  - stop goes to `ST_HALT`;
  - a bus byte arriving first goes to `ST_IDLE`.
- Data count: from a data state to its checksum state after the last byte.
- Checksum: from either checksum state to `ST_IDLE`.
- Engine reset: from any state to `ST_IDLE` on a mode change.

Top module: `lin_resp_engine`

## Requirements
- R1: A pulse on `rx_break` moves the engine to sync-wait and sets `active` one cycle later. The next byte must equal 8'h55. Any other value sets error bit 0 (sync), raises `irq` and returns the engine to idle (`active`=0).
- R2: The identifier byte carries the 6-bit identifier in bits [5:0], P0 in bit 6 and P1 in bit 7, where P0 = ID0^ID1^ID2^ID4 and P1 = ~(ID1^ID3^ID4^ID5).
  - With good parity, `dreq`=1, `id_out` shows the identifier and `irq`=1 one cycle after the byte.
  - With bad parity, error bit 1 (parity) is set, `irq` is raised and no data request is made.
- R3: An acknowledge (`ctl_ack`) with `ctl_dir`=1 makes the engine present the buffer bytes 0..n-1 and then the checksum on `tx_byte`. With `ctl_dir`=0, the next n bytes received are stored at buffer addresses 0..n-1, and the byte after them is taken as the checksum.
- R4: `ctl_len` values 0..8 give n directly, and values 9..14 give n=8. The value 4'hF decodes n from identifier bits [5:4]: 00 gives 2, 01 gives 2, 10 gives 4 and 11 gives 8.
- R5: `ctl_stop` during a data request (without `ctl_ack`) sends the engine to the halted state (`active`=0). All bytes are then ignored until the next break.
- R6: A byte received while the data request is still pending sets error bit 3 (timeout), raises `irq` and returns the engine to idle. No response is transmitted.
- R7: The checksum is the inverted 8-bit sum with end-around carry of the data bytes. When `cfg_enhanced`=1 the sum starts from the identifier byte. A received checksum that differs sets error bit 2 (checksum) and no done flag.
- R8: A change of `cfg_enhanced` or `cfg_master` while the engine is not idle returns it to idle and drops the frame, with no error and no interrupt. While `cfg_master`=1 the engine stays idle.
- R9: A frame that completes with a matching or transmitted checksum sets `done` and `irq` one cycle after the last byte, and clears `active`.
- R10: A `clr_int` pulse clears `irq` and `done`, and a `clr_err` pulse clears all error bits. A new event in the same cycle wins over the clear.
- R11: Host reads (`buf_rdata`, `id_out`) and writes (`buf_we`) take effect only while `dreq`=1 or `active`=0. Otherwise reads return 0 and writes are ignored.
- R12: While `tx_valid`=1 and `tx_ready`=0, `tx_valid` stays high and `tx_byte` stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | Master mode select; holds the engine idle |
| cfg_enhanced | input | 1 | 1 = enhanced checksum, 0 = classic |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| rx_break | input | 1 | Break detected pulse |
| tx_valid | output | 1 | Response byte offered to the transmitter |
| tx_byte | output | 8 | Response byte |
| tx_ready | input | 1 | Transmitter accepts the byte |
| ctl_dir | input | 1 | Frame direction: 1 = slave transmits |
| ctl_len | input | 4 | Data length code |
| ctl_ack | input | 1 | Acknowledge pulse |
| ctl_stop | input | 1 | Stop pulse |
| clr_int | input | 1 | Clear interrupt and done |
| clr_err | input | 1 | Clear error bits |
| buf_we | input | 1 | Host buffer write |
| buf_addr | input | ADDR_W | Host buffer address |
| buf_wdata | input | 8 | Host write data |
| buf_rdata | output | 8 | Host read data (gated) |
| id_out | output | 6 | Received identifier (gated) |
| dreq | output | 1 | Data request pending |
| active | output | 1 | Bus activity in progress |
| done | output | 1 | Frame completed |
| err | output | 4 | Error bits: 0 sync, 1 parity, 2 checksum, 3 timeout |
| irq | output | 1 | Interrupt request |

## Verification
Flags driven by a received byte (`dreq`, `done`, `err`, `irq`, `active`) appear one clock after the edge that samples the byte. `tx_valid` and the first `tx_byte` appear in the cycle after the acknowledge edge, and each following byte appears one cycle after the edge where `tx_ready` was high. Buffer reads are combinational through the access gate.

The bench drives every input on a falling edge and holds it for one full period. It samples all results at the next falling edge, where every one of these latencies has resolved, and it reads the buffer after a short settle delay. The bench sweeps all 64 identifiers with good and corrupted parity. It also runs every length code in both directions under both checksum modes, computing the data and checksums arithmetically.

// File: rtl/lin_resp_pkg.sv
package lin_resp_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SYNC,
        ST_PID,
        ST_WAIT_HOST,
        ST_RX_DATA,
        ST_RX_CKSUM,
        ST_TX_DATA,
        ST_TX_CKSUM,
        ST_HALT
    } lin_state_e;

    localparam int ERR_W       = 4;
    localparam int ERR_SYNC    = 0;
    localparam int ERR_PARITY  = 1;
    localparam int ERR_CKSUM   = 2;
    localparam int ERR_TIMEOUT = 3;

    // Byte count implied by identifier bits [5:4].
    function automatic logic [3:0] len_from_id(input logic [5:0] id);
        unique case (id[5:4])
            2'b10:   len_from_id = 4'd4;
            2'b11:   len_from_id = 4'd8;
            default: len_from_id = 4'd2;
        endcase
    endfunction

endpackage

// File: rtl/lin_pid_check.sv
module lin_pid_check (
    input  logic [7:0] pid,
    output logic [5:0] id,
    output logic       ok
);
    logic p0_calc;
    logic p1_calc;

    always_comb begin
        id      = pid[5:0];
        p0_calc = pid[0] ^ pid[1] ^ pid[2] ^ pid[4];
        p1_calc = ~(pid[1] ^ pid[3] ^ pid[4] ^ pid[5]);
        ok      = (pid[6] == p0_calc) && (pid[7] == p1_calc);
    end
endmodule

// File: rtl/lin_cksum_acc.sv
module lin_cksum_acc #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         init,
    input  logic [W-1:0] init_val,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum
);
    logic [W:0]   raw;
    logic [W-1:0] wrapped;

    always_comb begin
        raw     = {1'b0, sum} + {1'b0, din};
        wrapped = raw[W-1:0] + W'(raw[W]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    sum <= '0;
        else if (init) sum <= init_val;
        else if (add)  sum <= wrapped;
    end
endmodule

// File: rtl/lin_resp_buf.sv
module lin_resp_buf #(
    parameter int DEPTH  = 8,
    parameter int W      = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);
    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                        mem[g] <= '0;
            else if (we && waddr == AW'(g))    mem[g] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/lin_resp_engine.sv
module lin_resp_engine
    import lin_resp_pkg::*;
#(
    parameter int          MAX_BYTES = 8,
    parameter logic [7:0]  SYNC_BYTE = 8'h55,
    localparam int         ADDR_W    = $clog2(MAX_BYTES),
    localparam int         CNT_W     = $clog2(MAX_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_master,
    input  logic              cfg_enhanced,
    input  logic              rx_valid,
    input  logic [7:0]        rx_byte,
    input  logic              rx_break,
    output logic              tx_valid,
    output logic [7:0]        tx_byte,
    input  logic              tx_ready,
    input  logic              ctl_dir,
    input  logic [3:0]        ctl_len,
    input  logic              ctl_ack,
    input  logic              ctl_stop,
    input  logic              clr_int,
    input  logic              clr_err,
    input  logic              buf_we,
    input  logic [ADDR_W-1:0] buf_addr,
    input  logic [7:0]        buf_wdata,
    output logic [7:0]        buf_rdata,
    output logic [5:0]        id_out,
    output logic              dreq,
    output logic              active,
    output logic              done,
    output logic [ERR_W-1:0]  err,
    output logic              irq
);
    lin_state_e st_q, st_d;

    logic             enh_q, mst_q;
    logic             mode_chg;
    logic [5:0]       id_q;
    logic [CNT_W-1:0] cnt_q, idx_q, len_eff;
    logic             last_byte;
    logic             done_q, irq_q;
    logic [ERR_W-1:0] err_q, err_new;

    logic             ev_brk, ev_dreq, ev_ack, ev_done;
    logic             ck_init, ck_add, eng_we, tx_fire;
    logic [7:0]       ck_sum, ck_din, ck_init_val;
    logic [7:0]       eng_rdata, host_rdata;
    logic             access_ok, host_we_ok, mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [7:0]       mem_wdata;
    logic [5:0]       pid_id;
    logic             pid_ok;

    // ------------------------------------------------------------ sub-blocks
    lin_pid_check u_pid (
        .pid (rx_byte),
        .id  (pid_id),
        .ok  (pid_ok)
    );

    lin_cksum_acc #(.W(8)) u_ck (
        .clk      (clk),
        .rst_n    (rst_n),
        .init     (ck_init),
        .init_val (ck_init_val),
        .add      (ck_add),
        .din      (ck_din),
        .sum      (ck_sum)
    );

    lin_resp_buf #(.DEPTH(MAX_BYTES), .W(8)) u_buf (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (mem_we),
        .waddr   (mem_waddr),
        .wdata   (mem_wdata),
        .raddr_a (buf_addr),
        .rdata_a (host_rdata),
        .raddr_b (idx_q[ADDR_W-1:0]),
        .rdata_b (eng_rdata)
    );

    // ------------------------------------------------------------ helpers
    always_comb begin
        mode_chg  = (cfg_enhanced != enh_q) || (cfg_master != mst_q);
        last_byte = (idx_q + CNT_W'(1)) == cnt_q;
        if (ctl_len == 4'hF)
            len_eff = CNT_W'(len_from_id(id_q));
        else if (int'(ctl_len) > MAX_BYTES)
            len_eff = CNT_W'(MAX_BYTES);
        else
            len_eff = CNT_W'(ctl_len);
        ck_init_val = cfg_enhanced ? rx_byte : 8'h00;
        ck_din      = (st_q == ST_TX_DATA) ? eng_rdata : rx_byte;
    end

    // ------------------------------------------------------------ next state
    always_comb begin
        st_d    = st_q;
        ev_brk  = 1'b0;
        ev_dreq = 1'b0;
        ev_ack  = 1'b0;
        ev_done = 1'b0;
        err_new = '0;
        ck_init = 1'b0;
        ck_add  = 1'b0;
        eng_we  = 1'b0;
        if (cfg_master || (mode_chg && st_q != ST_IDLE)) begin
            st_d = ST_IDLE;
        end else if (rx_break) begin
            st_d   = ST_SYNC;
            ev_brk = 1'b1;
        end else begin
            unique case (st_q)
                ST_IDLE, ST_HALT: st_d = st_q;
                ST_SYNC: if (rx_valid) begin
                    if (rx_byte == SYNC_BYTE) st_d = ST_PID;
                    else begin
                        st_d              = ST_IDLE;
                        err_new[ERR_SYNC] = 1'b1;
                    end
                end
                ST_PID: if (rx_valid) begin
                    if (pid_ok) begin
                        st_d    = ST_WAIT_HOST;
                        ev_dreq = 1'b1;
                        ck_init = 1'b1;
                    end else begin
                        st_d                = ST_IDLE;
                        err_new[ERR_PARITY] = 1'b1;
                    end
                end
                ST_WAIT_HOST: begin
                    if (ctl_ack) begin
                        ev_ack = 1'b1;
                        if (ctl_dir) st_d = (len_eff == '0) ? ST_TX_CKSUM : ST_TX_DATA;
                        else         st_d = (len_eff == '0) ? ST_RX_CKSUM : ST_RX_DATA;
                    end else if (ctl_stop) begin
                        st_d = ST_HALT;
                    end else if (rx_valid) begin
                        st_d                 = ST_IDLE;
                        err_new[ERR_TIMEOUT] = 1'b1;
                    end
                end
                ST_RX_DATA: if (rx_valid) begin
                    eng_we = 1'b1;
                    ck_add = 1'b1;
                    if (last_byte) st_d = ST_RX_CKSUM;
                end
                ST_RX_CKSUM: if (rx_valid) begin
                    st_d = ST_IDLE;
                    if (rx_byte == ~ck_sum) ev_done = 1'b1;
                    else                    err_new[ERR_CKSUM] = 1'b1;
                end
                ST_TX_DATA: if (tx_fire) begin
                    ck_add = 1'b1;
                    if (last_byte) st_d = ST_TX_CKSUM;
                end
                ST_TX_CKSUM: if (tx_fire) begin
                    st_d    = ST_IDLE;
                    ev_done = 1'b1;
                end
                default: st_d = ST_IDLE;
            endcase
        end
    end

    // ------------------------------------------------------------ state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // ------------------------------------------------------------ datapath / flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enh_q  <= 1'b0;
            mst_q  <= 1'b0;
            id_q   <= '0;
            cnt_q  <= '0;
            idx_q  <= '0;
            done_q <= 1'b0;
            irq_q  <= 1'b0;
            err_q  <= '0;
        end else begin
            enh_q <= cfg_enhanced;
            mst_q <= cfg_master;
            if (ev_dreq) id_q <= pid_id;
            if (ev_ack) begin
                cnt_q <= len_eff;
                idx_q <= '0;
            end else if (ck_add) begin
                idx_q <= idx_q + CNT_W'(1);
            end
            if (ev_done)                done_q <= 1'b1;
            else if (clr_int || ev_brk) done_q <= 1'b0;
            if (ev_dreq || ev_done || (err_new != '0)) irq_q <= 1'b1;
            else if (clr_int)                          irq_q <= 1'b0;
            err_q <= (clr_err ? '0 : err_q) | err_new;
        end
    end

    // ------------------------------------------------------------ outputs
    always_comb begin
        active     = !(st_q inside {ST_IDLE, ST_HALT});
        dreq       = (st_q == ST_WAIT_HOST);
        tx_valid   = (st_q == ST_TX_DATA) || (st_q == ST_TX_CKSUM);
        tx_byte    = (st_q == ST_TX_CKSUM) ? ~ck_sum : eng_rdata;
        tx_fire    = tx_valid && tx_ready;
        access_ok  = dreq || !active;
        host_we_ok = buf_we && access_ok;
        mem_we     = eng_we || host_we_ok;
        mem_waddr  = eng_we ? idx_q[ADDR_W-1:0] : buf_addr;
        mem_wdata  = eng_we ? rx_byte : buf_wdata;
        buf_rdata  = access_ok ? host_rdata : 8'h00;
        id_out     = access_ok ? id_q : 6'h00;
        done       = done_q;
        irq        = irq_q;
        err        = err_q;
    end
endmodule

// File: rtl/lin_resp_engine_chk.sv
module lin_resp_engine_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_master,
    input logic       cfg_enhanced,
    input logic       rx_valid,
    input logic       rx_break,
    input logic       tx_valid,
    input logic [7:0] tx_byte,
    input logic       tx_ready,
    input logic       ctl_ack,
    input logic       ctl_stop,
    input logic       dreq,
    input logic       active,
    input logic       done,
    input logic       irq
);
    a_r2_dreq_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dreq) |-> irq);

    a_r9_done_irq: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> irq);

    a_r11_dreq_active: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> active);

    a_r3_no_tx_while_dreq: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> !tx_valid);

    a_r5_stop_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (dreq && ctl_stop && !ctl_ack && !rx_break && !rx_valid && !cfg_master
         && $stable(cfg_enhanced) && $stable(cfg_master))
        |=> (!active && !dreq));

    a_r12_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !rx_break && !cfg_master
         && $stable(cfg_enhanced) && $stable(cfg_master))
        |=> (tx_valid && $stable(tx_byte)));
endmodule

bind lin_resp_engine lin_resp_engine_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_master   (cfg_master),
    .cfg_enhanced (cfg_enhanced),
    .rx_valid     (rx_valid),
    .rx_break     (rx_break),
    .tx_valid     (tx_valid),
    .tx_byte      (tx_byte),
    .tx_ready     (tx_ready),
    .ctl_ack      (ctl_ack),
    .ctl_stop     (ctl_stop),
    .dreq         (dreq),
    .active       (active),
    .done         (done),
    .irq          (irq)
);

// File: tb/test_lin_resp_engine.sv
module test_lin_resp_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_master = 1'b0, cfg_enhanced = 1'b0;
    logic       rx_valid = 1'b0, rx_break = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       tx_ready = 1'b1;
    logic       ctl_dir = 1'b0, ctl_ack = 1'b0, ctl_stop = 1'b0;
    logic [3:0] ctl_len = 4'h0;
    logic       clr_int = 1'b0, clr_err = 1'b0;
    logic       buf_we = 1'b0;
    logic [2:0] buf_addr = 3'd0;
    logic [7:0] buf_wdata = 8'h00;
    logic [7:0] buf_rdata;
    logic [5:0] id_out;
    logic       dreq, active, done, irq;
    logic [3:0] err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    lin_resp_engine i_lin_resp_engine (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_enhanced(cfg_enhanced),
        .rx_valid(rx_valid), .rx_byte(rx_byte), .rx_break(rx_break),
        .tx_valid(tx_valid), .tx_byte(tx_byte), .tx_ready(tx_ready),
        .ctl_dir(ctl_dir), .ctl_len(ctl_len), .ctl_ack(ctl_ack), .ctl_stop(ctl_stop),
        .clr_int(clr_int), .clr_err(clr_err), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .buf_rdata(buf_rdata), .id_out(id_out), .dreq(dreq),
        .active(active), .done(done), .err(err), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pid_of(input logic [5:0] id);
        logic p0, p1;
        p0 = id[0] ^ id[1] ^ id[2] ^ id[4];
        p1 = ~(id[1] ^ id[3] ^ id[4] ^ id[5]);
        return {p1, p0, id};
    endfunction

    function automatic logic [7:0] add8(input logic [7:0] s, input logic [7:0] b);
        logic [8:0] t;
        t = {1'b0, s} + {1'b0, b};
        return t[7:0] + {7'd0, t[8]};
    endfunction

    function automatic int exp_len(input logic [3:0] code, input logic [5:0] id);
        if (code == 4'hF) return (id[5:4] == 2'b11) ? 8 : (id[5:4] == 2'b10) ? 4 : 2;
        return (code > 8) ? 8 : int'(code);
    endfunction

    function automatic logic [7:0] dat(input logic [5:0] id, input int i, input int k);
        return 8'((int'(id) * 7 + i * 29 + k * 3 + 11) & 255);
    endfunction

    task automatic send(input logic [7:0] b);
        @(negedge clk); rx_valid = 1'b1; rx_byte = b;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic brk();
        @(negedge clk); rx_break = 1'b1;
        @(negedge clk); rx_break = 1'b0;
    endtask

    task automatic header(input logic [5:0] id);
        brk();
        send(8'h55);
        send(pid_of(id));
    endtask

    task automatic pulse_clr();
        @(negedge clk); clr_int = 1'b1; clr_err = 1'b1;
        @(negedge clk); clr_int = 1'b0; clr_err = 1'b0;
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); buf_we = 1'b1; buf_addr = a; buf_wdata = d;
        @(negedge clk); buf_we = 1'b0;
    endtask

    task automatic ack(input logic dir, input logic [3:0] len);
        @(negedge clk); ctl_dir = dir; ctl_len = len; ctl_ack = 1'b1;
        @(negedge clk); ctl_ack = 1'b0;
    endtask

    task automatic stop();
        @(negedge clk); ctl_stop = 1'b1;
        @(negedge clk); ctl_stop = 1'b0;
    endtask

    task automatic run_frame(input logic enh, input logic dir, input logic [3:0] code,
                             input logic [5:0] id, input int k);
        int n;
        logic [7:0] s;
        n = exp_len(code, id);
        @(negedge clk); cfg_enhanced = enh;
        header(id);
        chk(dreq && id_out == id, "R2", {dreq, id_out}, {1'b1, id});
        if (dir) for (int i = 0; i < 8; i++) host_wr(3'(i), dat(id, i, k));
        s = enh ? pid_of(id) : 8'h00;
        for (int i = 0; i < n; i++) s = add8(s, dat(id, i, k));
        ack(dir, code);
        if (dir) begin
            for (int i = 0; i < n; i++) begin
                chk(tx_valid && tx_byte == dat(id, i, k), "R3", tx_byte, dat(id, i, k));
                @(negedge clk);
            end
            chk(tx_valid && tx_byte == ~s, "R7", tx_byte, ~s);
            @(negedge clk);
        end else begin
            for (int i = 0; i < n; i++) send(dat(id, i, k));
            send(~s);
        end
        chk(done && irq && !active && err == 4'h0, "R9", {done, irq, active, err}, 7'b1100000);
        if (!dir) begin
            for (int i = 0; i < n; i++) begin
                @(negedge clk); buf_addr = 3'(i);
                #1 chk(buf_rdata == dat(id, i, k), "R3", buf_rdata, dat(id, i, k));
            end
        end
        // R4: length check via final state of tx count is covered by byte-accurate compare
        pulse_clr();
        chk(!done && !irq, "R10", {done, irq}, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] s;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!active && !dreq && !irq && !done && err == 0 && !tx_valid, "R1",
            {active, dreq, irq, done, err, tx_valid}, 0);

        // R2/R5: all identifiers, good then corrupted parity
        for (int id = 0; id < 64; id++) begin
            header(6'(id));
            chk(dreq && irq && id_out == 6'(id), "R2", {dreq, irq, id_out}, {2'b11, 6'(id)});
            stop();
            chk(!active && !dreq, "R5", {active, dreq}, 0);
            pulse_clr();
            brk();
            send(8'h55);
            send(pid_of(6'(id)) ^ 8'h40);
            chk(!dreq && err == 4'b0010 && irq, "R2", {dreq, err, irq}, 6'b000101);
            pulse_clr();
            chk(err == 0 && !irq, "R10", {err, irq}, 0);
        end

        // R1: sync check
        brk();
        chk(active, "R1", active, 1);
        send(8'h54);
        chk(!active && err == 4'b0001 && irq, "R1", {active, err, irq}, 6'b000011);
        pulse_clr();

        // R3/R4/R7/R9: every length code, both directions, both checksum modes
        for (int e = 0; e < 2; e++)
            for (int d = 0; d < 2; d++)
                for (int c = 0; c < 16; c++)
                    run_frame(1'(e), 1'(d), 4'(c), 6'((c * 13 + d * 5 + e * 17 + (c == 15 ? e * 32 + d * 16 : 0)) & 63), c);
        // R4: length 15 decode for all four id[5:4] codings, receive direction
        for (int h = 0; h < 4; h++) run_frame(1'b0, 1'b0, 4'hF, 6'(h * 16 + 3), h + 40);

        // R7: wrong checksum on receive
        @(negedge clk); cfg_enhanced = 1'b0;
        header(6'h12);
        ack(1'b0, 4'd2);
        send(8'h10); send(8'h20);
        send(8'h00);
        chk(!done && err == 4'b0100 && irq, "R7", {done, err, irq}, 6'b001001);
        pulse_clr();

        // R6: byte arrives before acknowledge
        header(6'h21);
        send(8'hA5);
        chk(!active && err == 4'b1000 && irq && !tx_valid, "R6", {active, err, irq}, 6'b010001);
        pulse_clr();

        // R5: bytes ignored after stop until break
        header(6'h05);
        stop();
        send(8'h55);
        send(pid_of(6'h06));
        chk(!dreq && !active && err == 0, "R5", {dreq, active, err}, 0);
        header(6'h06);
        chk(dreq && id_out == 6'h06, "R5", {dreq, id_out}, 7'h46);
        stop();
        pulse_clr();

        // R8: checksum mode change during request
        header(6'h0A);
        pulse_clr();
        @(negedge clk); cfg_enhanced = 1'b1;
        @(negedge clk);
        chk(!active && !dreq && err == 0 && !irq, "R8", {active, dreq, err, irq}, 0);
        // R8: master select during reception
        header(6'h0B);
        ack(1'b0, 4'd4);
        send(8'h01);
        pulse_clr();
        @(negedge clk); cfg_master = 1'b1;
        @(negedge clk);
        chk(!active && err == 0 && !irq, "R8", {active, err, irq}, 0);
        brk();
        chk(!active, "R8", active, 0);
        @(negedge clk); cfg_master = 1'b0;
        @(negedge clk);

        // R11: access gate during reception
        @(negedge clk); cfg_enhanced = 1'b0;
        header(6'h0C);
        ack(1'b0, 4'd4);
        send(8'h31);
        host_wr(3'd1, 8'hEE);
        @(negedge clk); buf_addr = 3'd0;
        #1 chk(buf_rdata == 8'h00 && id_out == 6'h00, "R11", {buf_rdata, id_out}, 0);
        send(8'h32); send(8'h33); send(8'h34);
        s = add8(add8(add8(8'h31, 8'h32), 8'h33), 8'h34);
        send(~s);
        chk(done, "R9", done, 1);
        @(negedge clk); buf_addr = 3'd1;
        #1 chk(buf_rdata == 8'h32, "R11", buf_rdata, 8'h32);
        pulse_clr();

        // R12: transmitter back-pressure
        header(6'h0D);
        host_wr(3'd0, 8'h77);
        host_wr(3'd1, 8'h88);
        @(negedge clk); tx_ready = 1'b0;
        ack(1'b1, 4'd2);
        for (int i = 0; i < 3; i++) begin
            chk(tx_valid && tx_byte == 8'h77, "R12", tx_byte, 8'h77);
            @(negedge clk);
        end
        tx_ready = 1'b1;
        @(negedge clk);
        chk(tx_valid && tx_byte == 8'h88, "R12", tx_byte, 8'h88);
        @(negedge clk);
        s = ~add8(8'h77, 8'h88);
        chk(tx_valid && tx_byte == s, "R7", tx_byte, s);
        @(negedge clk);
        chk(done && !active, "R9", {done, active}, 2'b10);
        pulse_clr();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule